// File: doc/BRIEF.md
# SD Host Command Issue and Status Unit

This unit sits between a register bus and a bit-serial command engine in an SD host controller. Software writes an argument register and then a command word. The unit decodes the word into a command index, a response type, a data-present flag and two check enables. It refuses the command while a conflicting transfer is still marked busy. Otherwise it hands the command to the serializer with a one-cycle start strobe.

When the serializer reports completion, the unit decides which errors apply, stores the response in four 32-bit words and records the events in an interrupt status register. That register is cleared by writing ones, and a per-bit enable selects which of its bits drive the interrupt line. Two inhibit flags show whether the command line and the data line are free. Each flag can be released by a self-clearing reset bit in the control register.

Register word addresses: 0 argument, 1 command word, 2–5 response words 0–3, 6 line status, 7 control, 8 interrupt status, 9 interrupt enable.

Top module: `sd_cmd_ctrl`

## Requirements
- R1: A command word write accepted while status bit 0 (command inhibit) is clear pulses `ser_start_o` for one cycle. The pulse carries index = word[29:24], response type = word[17:16] (0 none, 1 136-bit, 2 48-bit, 3 48-bit with busy) and the previously written argument, and status bit 0 reads 1 from the next cycle.
- R2: A command word write is ignored, with no start and no state change, while status bit 0 is set, or while status bit 1 (data inhibit) is set and the word has data-present (bit 21) set or uses response type 3. A command with neither is accepted while only bit 1 is set.
- R3: Accepting a command with data-present or response type 3 sets status bit 1.
- R4: A completion from the serializer clears status bit 0. If it carries no applicable error, it sets interrupt bit 0 (command done).
- R5: A 48-bit response is stored in response word 0 as `ser_resp_i[31:0]`. A 136-bit response drops its trailing CRC byte: words 0..3 read `ser_resp_i[39:8]`, `[71:40]`, `[103:72]` and `{8'h00, [127:104]}`. A timed-out command stores nothing.
- R6: Command errors set interrupt bits 16 (timeout), 17 (CRC, only when word bit 19 is set), 18 (end bit) and 19 (index mismatch, only when word bit 20 is set and the type is 2 or 3). A timeout masks the other three. Any error suppresses bit 0.
- R7: After an error-free completion of a type-3 command, interrupt bit 1 (transfer done) is set and status bit 1 is cleared in the first cycle where `dat_busy_i` is low.
- R8: `data_done_i` sets interrupt bit 1 and clears status bit 1. `data_err_i[0..2]` set bits 20..22, `acmd_err_i` sets bit 24, `buf_wr_rdy_i` sets bit 4 and `buf_rd_rdy_i` sets bit 5.
- R9: Writing the interrupt status register clears each bit written as 1 and leaves bits written as 0 unchanged. An event on a bit in the same cycle as its clear leaves the bit set.
- R10: `irq_o` is high exactly when some interrupt status bit and the same interrupt enable bit are both 1.
- R11: Control bit 25 reads 1 for the one cycle after it is written and then clears status bit 0. A completion that arrives after this is ignored. Control bit 26 behaves the same way for status bit 1.
- R12: After reset, all registers read 0, `irq_o` is 0 and `ser_start_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read word address |
| rd_data_o | output | 32 | Register read data (combinational) |
| ser_start_o | output | 1 | One-cycle command launch to serializer |
| ser_idx_o | output | 6 | Command index for serializer |
| ser_arg_o | output | 32 | Command argument for serializer |
| ser_rsp_o | output | 2 | Expected response type |
| ser_done_i | input | 1 | Serializer completion pulse |
| ser_resp_i | input | 128 | Received response payload |
| ser_idx_i | input | 6 | Index field found in the response |
| ser_timeout_i | input | 1 | No response seen (with done) |
| ser_crc_bad_i | input | 1 | Response CRC mismatch (with done) |
| ser_end_bad_i | input | 1 | Response end bit wrong (with done) |
| dat_busy_i | input | 1 | Card holds the data line busy |
| data_done_i | input | 1 | Data path finished a transfer |
| data_err_i | input | 3 | Data timeout, CRC, end-bit errors |
| acmd_err_i | input | 1 | Automatic command error pulse |
| buf_wr_rdy_i | input | 1 | Buffer ready for write data |
| buf_rd_rdy_i | input | 1 | Buffer holds read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a software clear of an interrupt status bit and a hardware event on that same bit. The bench drives a write-one-to-clear of bit 4 in the same cycle as a `buf_wr_rdy_i` pulse, and passes only if bit 4 still reads 1 afterwards. The second pair is a command reset and a late response. The bench resets the command line while a command is outstanding and then delivers its completion; the line must stay free and no command-done bit may appear.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned IDX_W  = 6;

  localparam logic [REG_AW-1:0] A_ARG   = 4'd0;
  localparam logic [REG_AW-1:0] A_CMD   = 4'd1;
  localparam logic [REG_AW-1:0] A_RSP0  = 4'd2;
  localparam logic [REG_AW-1:0] A_STAT  = 4'd6;
  localparam logic [REG_AW-1:0] A_CTRL  = 4'd7;
  localparam logic [REG_AW-1:0] A_ISTAT = 4'd8;
  localparam logic [REG_AW-1:0] A_IEN   = 4'd9;

  localparam logic [1:0] RSP_NONE = 2'd0;
  localparam logic [1:0] RSP_136  = 2'd1;
  localparam logic [1:0] RSP_48   = 2'd2;
  localparam logic [1:0] RSP_48B  = 2'd3;

  // interrupt status bit positions
  localparam int unsigned IB_CDONE = 0;
  localparam int unsigned IB_XDONE = 1;
  localparam int unsigned IB_WRDY  = 4;
  localparam int unsigned IB_RRDY  = 5;
  localparam int unsigned IB_CTO   = 16;
  localparam int unsigned IB_CCRC  = 17;
  localparam int unsigned IB_CEND  = 18;
  localparam int unsigned IB_CIDX  = 19;
  localparam int unsigned IB_DERR  = 20;
  localparam int unsigned IB_ACMD  = 24;
  localparam logic [31:0] ISTAT_MASK = 32'h017F_0033;

  localparam int unsigned CB_RCMD = 25;
  localparam int unsigned CB_RDAT = 26;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [1:0]       rsp;
    logic             dat;
    logic             idx_chk;
    logic             crc_chk;
  } cmd_t;
endpackage

// File: rtl/sd_cmd_decode.sv
module sd_cmd_decode
  import sd_cmd_pkg::*;
(
  input  logic [31:0] word_i,
  output cmd_t        cmd_o,
  output logic        needs_dat_o
);
  always_comb begin
    cmd_o.idx     = word_i[24 +: IDX_W];
    cmd_o.rsp     = word_i[17:16];
    cmd_o.dat     = word_i[21];
    cmd_o.idx_chk = word_i[20];
    cmd_o.crc_chk = word_i[19];
    needs_dat_o   = cmd_o.dat || (cmd_o.rsp == RSP_48B);
  end
endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
  import sd_cmd_pkg::*;
#(
  parameter int unsigned ARG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  cmd_t             cmd_i,
  input  logic             needs_dat_i,
  input  logic [ARG_W-1:0] arg_i,
  input  logic             rst_cmd_i,
  input  logic             rst_dat_i,
  input  logic             ser_done_i,
  input  logic             ser_timeout_i,
  input  logic             ser_crc_bad_i,
  input  logic             ser_end_bad_i,
  input  logic [IDX_W-1:0] ser_idx_i,
  input  logic             dat_busy_i,
  input  logic             data_done_i,
  output logic             ser_start_o,
  output logic [ARG_W-1:0] ser_arg_o,
  output cmd_t             cur_o,
  output logic             cmd_inh_o,
  output logic             dat_inh_o,
  output logic             rsp_we_o,
  output logic             ev_cdone_o,
  output logic             ev_xdone_o,
  output logic [3:0]       ev_cerr_o
);
  logic             cmd_inh_q, dat_inh_q, busy_wait_q, start_q;
  cmd_t             cur_q;
  logic [ARG_W-1:0] arg_q;
  logic             accept, done_ok, busy_rel, any_err, rsp_has_idx;
  logic             e_to, e_crc, e_end, e_idx;

  assign accept   = cmd_wr_i && !cmd_inh_q && !rst_cmd_i && !(needs_dat_i && dat_inh_q);
  assign done_ok  = cmd_inh_q && ser_done_i && !rst_cmd_i;
  assign busy_rel = busy_wait_q && !dat_busy_i && !rst_dat_i;

  assign rsp_has_idx = (cur_q.rsp == RSP_48) || (cur_q.rsp == RSP_48B);
  assign e_to   = ser_timeout_i;
  assign e_crc  = !e_to && cur_q.crc_chk && ser_crc_bad_i;
  assign e_end  = !e_to && ser_end_bad_i;
  assign e_idx  = !e_to && cur_q.idx_chk && rsp_has_idx && (ser_idx_i != cur_q.idx);
  assign any_err = e_to || e_crc || e_end || e_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_inh_q   <= 1'b0;
      dat_inh_q   <= 1'b0;
      busy_wait_q <= 1'b0;
      start_q     <= 1'b0;
      cur_q       <= '0;
      arg_q       <= '0;
    end else begin
      start_q <= accept;
      if (accept) begin
        cur_q <= cmd_i;
        arg_q <= arg_i;
      end
      if (rst_cmd_i || done_ok) cmd_inh_q <= 1'b0;
      else if (accept)          cmd_inh_q <= 1'b1;
      if (rst_dat_i || busy_rel)                      busy_wait_q <= 1'b0;
      else if (done_ok && !any_err && cur_q.rsp == RSP_48B) busy_wait_q <= 1'b1;
      // new data command wins over a release in the same cycle
      if (accept && needs_dat_i)                      dat_inh_q <= 1'b1;
      else if (rst_dat_i || data_done_i || busy_rel)  dat_inh_q <= 1'b0;
    end
  end

  assign ser_start_o = start_q;
  assign ser_arg_o   = arg_q;
  assign cur_o       = cur_q;
  assign cmd_inh_o   = cmd_inh_q;
  assign dat_inh_o   = dat_inh_q;
  assign rsp_we_o    = done_ok && !e_to && (cur_q.rsp != RSP_NONE);
  assign ev_cdone_o  = done_ok && !any_err;
  assign ev_xdone_o  = data_done_i || busy_rel;
  assign ev_cerr_o   = done_ok ? {e_idx, e_end, e_crc, e_to} : 4'b0;
endmodule

// File: rtl/sd_rsp_store.sv
module sd_rsp_store
  import sd_cmd_pkg::*;
#(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned WORD_W = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [1:0]                   rsp_i,
  input  logic [WORDS*WORD_W-1:0]      raw_i,
  output logic [WORDS-1:0][WORD_W-1:0] words_o
);
  localparam int unsigned RAW_W = WORDS * WORD_W;
  localparam int unsigned CRC_W = 8;

  logic [RAW_W-1:0] long_pk;
  assign long_pk = {{CRC_W{1'b0}}, raw_i[RAW_W-1:CRC_W]};

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        words_o[i] <= '0;
      end else if (we_i) begin
        if (rsp_i == RSP_136) words_o[i] <= long_pk[i*WORD_W +: WORD_W];
        else if (i == 0)      words_o[i] <= raw_i[WORD_W-1:0];
      end
    end
  end
endmodule

// File: rtl/sd_int_regs.sv
module sd_int_regs
  import sd_cmd_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = ISTAT_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ev_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] clr;
  assign clr = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
      en_o   <= '0;
    end else begin
      stat_o <= ((stat_o & ~clr) | ev_i) & MASK;
      if (en_we_i) en_o <= wdata_i & MASK;
    end
  end

  assign irq_o = |(stat_o & en_o);
endmodule

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
#(
  parameter int unsigned ARG_W     = 32,
  parameter int unsigned RSP_WORDS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [REG_AW-1:0]         wr_addr_i,
  input  logic [31:0]               wr_data_i,
  input  logic [REG_AW-1:0]         rd_addr_i,
  output logic [31:0]               rd_data_o,
  output logic                      ser_start_o,
  output logic [IDX_W-1:0]          ser_idx_o,
  output logic [ARG_W-1:0]          ser_arg_o,
  output logic [1:0]                ser_rsp_o,
  input  logic                      ser_done_i,
  input  logic [RSP_WORDS*32-1:0]   ser_resp_i,
  input  logic [IDX_W-1:0]          ser_idx_i,
  input  logic                      ser_timeout_i,
  input  logic                      ser_crc_bad_i,
  input  logic                      ser_end_bad_i,
  input  logic                      dat_busy_i,
  input  logic                      data_done_i,
  input  logic [2:0]                data_err_i,
  input  logic                      acmd_err_i,
  input  logic                      buf_wr_rdy_i,
  input  logic                      buf_rd_rdy_i,
  output logic                      irq_o
);
  logic [ARG_W-1:0] arg_q;
  logic             rst_cmd_q, rst_dat_q;
  logic             wr_arg, wr_cmd, wr_ctrl, wr_istat, wr_ien;
  cmd_t             dec_cmd, cur_cmd;
  logic             dec_needs_dat;
  logic             cmd_inh, dat_inh, rsp_we, ev_cdone, ev_xdone;
  logic [3:0]       ev_cerr;
  logic [31:0]      ev, int_stat, int_en;
  logic [RSP_WORDS-1:0][31:0] rsp_words;

  assign wr_arg   = wr_en_i && wr_addr_i == A_ARG;
  assign wr_cmd   = wr_en_i && wr_addr_i == A_CMD;
  assign wr_ctrl  = wr_en_i && wr_addr_i == A_CTRL;
  assign wr_istat = wr_en_i && wr_addr_i == A_ISTAT;
  assign wr_ien   = wr_en_i && wr_addr_i == A_IEN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_q     <= '0;
      rst_cmd_q <= 1'b0;
      rst_dat_q <= 1'b0;
    end else begin
      if (wr_arg) arg_q <= wr_data_i[ARG_W-1:0];
      // reset strobes live for exactly one cycle
      rst_cmd_q <= wr_ctrl && wr_data_i[CB_RCMD];
      rst_dat_q <= wr_ctrl && wr_data_i[CB_RDAT];
    end
  end

  sd_cmd_decode u_dec (
    .word_i      (wr_data_i),
    .cmd_o       (dec_cmd),
    .needs_dat_o (dec_needs_dat)
  );

  sd_cmd_seq #(.ARG_W(ARG_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_wr_i      (wr_cmd),
    .cmd_i         (dec_cmd),
    .needs_dat_i   (dec_needs_dat),
    .arg_i         (arg_q),
    .rst_cmd_i     (rst_cmd_q),
    .rst_dat_i     (rst_dat_q),
    .ser_done_i    (ser_done_i),
    .ser_timeout_i (ser_timeout_i),
    .ser_crc_bad_i (ser_crc_bad_i),
    .ser_end_bad_i (ser_end_bad_i),
    .ser_idx_i     (ser_idx_i),
    .dat_busy_i    (dat_busy_i),
    .data_done_i   (data_done_i),
    .ser_start_o   (ser_start_o),
    .ser_arg_o     (ser_arg_o),
    .cur_o         (cur_cmd),
    .cmd_inh_o     (cmd_inh),
    .dat_inh_o     (dat_inh),
    .rsp_we_o      (rsp_we),
    .ev_cdone_o    (ev_cdone),
    .ev_xdone_o    (ev_xdone),
    .ev_cerr_o     (ev_cerr)
  );

  assign ser_idx_o = cur_cmd.idx;
  assign ser_rsp_o = cur_cmd.rsp;

  sd_rsp_store #(.WORDS(RSP_WORDS), .WORD_W(32)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rsp_we),
    .rsp_i   (cur_cmd.rsp),
    .raw_i   (ser_resp_i),
    .words_o (rsp_words)
  );

  always_comb begin
    ev = '0;
    ev[IB_CDONE]          = ev_cdone;
    ev[IB_XDONE]          = ev_xdone;
    ev[IB_WRDY]           = buf_wr_rdy_i;
    ev[IB_RRDY]           = buf_rd_rdy_i;
    ev[IB_CTO +: 4]       = ev_cerr;
    ev[IB_DERR +: 3]      = data_err_i;
    ev[IB_ACMD]           = acmd_err_i;
  end

  sd_int_regs #(.W(32), .MASK(ISTAT_MASK)) u_int (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .clr_we_i (wr_istat),
    .en_we_i  (wr_ien),
    .wdata_i  (wr_data_i),
    .stat_o   (int_stat),
    .en_o     (int_en),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_ARG) rd_data_o[ARG_W-1:0] = arg_q;
    else if (rd_addr_i >= A_RSP0 && rd_addr_i < A_RSP0 + RSP_WORDS)
      rd_data_o = rsp_words[rd_addr_i - A_RSP0];
    else if (rd_addr_i == A_STAT)  rd_data_o[1:0] = {dat_inh, cmd_inh};
    else if (rd_addr_i == A_CTRL) begin
      rd_data_o[CB_RCMD] = rst_cmd_q;
      rd_data_o[CB_RDAT] = rst_dat_q;
    end
    else if (rd_addr_i == A_ISTAT) rd_data_o = int_stat;
    else if (rd_addr_i == A_IEN)   rd_data_o = int_en;
  end
endmodule

// File: rtl/sd_cmd_ctrl_chk.sv
module sd_cmd_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [3:0]  wr_addr_i,
  input logic [31:0] wr_data_i,
  input logic        ser_start_o,
  input logic        cmd_inh,
  input logic        rst_cmd_q,
  input logic [31:0] ev,
  input logic [31:0] int_stat,
  input logic        cur_idx_chk,
  input logic        cur_crc_chk
);
  p_start_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_start_o |=> !ser_start_o);
  p_start_inh_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_start_o |-> cmd_inh);
  p_busy_ignore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 4'd1 && cmd_inh) |=> !ser_start_o);
  p_idx_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_stat[19]) |-> $past(cur_idx_chk));
  p_crc_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_stat[17]) |-> $past(cur_crc_chk));
  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 4'd8 && wr_data_i[0] && !ev[0]) |=> !int_stat[0]);
  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev[0] |=> int_stat[0]);
  p_cmd_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cmd_q |=> !cmd_inh);
endmodule

bind sd_cmd_ctrl sd_cmd_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .ser_start_o (ser_start_o),
  .cmd_inh     (cmd_inh),
  .rst_cmd_q   (rst_cmd_q),
  .ev          (ev),
  .int_stat    (int_stat),
  .cur_idx_chk (cur_cmd.idx_chk),
  .cur_crc_chk (cur_cmd.crc_chk)
);

// File: tb/sd_cmd_ctrl_bench.sv
module sd_cmd_ctrl_bench;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [3:0]   wr_addr = '0, rd_addr = '0;
  logic [31:0]  wr_data = '0, rd_data;
  logic         ser_start;
  logic [5:0]   ser_idx;
  logic [31:0]  ser_arg;
  logic [1:0]   ser_rsp;
  logic         ser_done = 0, ser_to = 0, ser_crc = 0, ser_end = 0;
  logic [127:0] ser_resp = '0;
  logic [5:0]   ser_ridx = '0;
  logic         dat_busy = 0, data_done = 0, acmd_err = 0, wr_rdy = 0, rd_rdy = 0;
  logic [2:0]   data_err = '0;
  logic         irq;
  int checks = 0, failures = 0;
  logic [39:0]  exp_q[$];

  always #2.5 clk = ~clk;

  sd_cmd_ctrl u_sd_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ser_start_o(ser_start), .ser_idx_o(ser_idx), .ser_arg_o(ser_arg),
    .ser_rsp_o(ser_rsp), .ser_done_i(ser_done), .ser_resp_i(ser_resp),
    .ser_idx_i(ser_ridx), .ser_timeout_i(ser_to), .ser_crc_bad_i(ser_crc),
    .ser_end_bad_i(ser_end), .dat_busy_i(dat_busy), .data_done_i(data_done),
    .data_err_i(data_err), .acmd_err_i(acmd_err), .buf_wr_rdy_i(wr_rdy),
    .buf_rd_rdy_i(rd_rdy), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [31:0] mk(input int idx, input bit dat, input bit ic,
                                     input bit cc, input logic [1:0] rsp);
    return (32'(idx) << 24) | (32'(dat) << 21) | (32'(ic) << 20) | (32'(cc) << 19)
           | (32'(rsp) << 16);
  endfunction

  // driver: queue the expected launch then write the registers
  task automatic issue(input logic [31:0] w, input logic [31:0] arg, input bit launch);
    wr(4'd0, arg);
    if (launch) exp_q.push_back({w[29:24], arg, w[17:16]});
    wr(4'd1, w);
  endtask

  task automatic respond(input logic [127:0] r, input logic [5:0] ri,
                         input bit to, input bit crc, input bit eb);
    @(negedge clk);
    ser_done = 1; ser_resp = r; ser_ridx = ri; ser_to = to; ser_crc = crc; ser_end = eb;
    @(negedge clk);
    ser_done = 0; ser_to = 0; ser_crc = 0; ser_end = 0;
  endtask

  // monitor: every launch must match the oldest queued expectation
  always @(negedge clk) begin
    if (rst_n && ser_start) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R2 unexpected launch actual=%h expected=none", {ser_idx, ser_arg, ser_rsp});
      end else begin
        logic [39:0] e;
        e = exp_q.pop_front();
        if ({ser_idx, ser_arg, ser_rsp} !== e) begin
          failures++;
          $display("FAIL R1 launch actual=%h expected=%h", {ser_idx, ser_arg, ser_rsp}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk_reg("R12 status", 4'd6, 0);
    chk_reg("R12 istat", 4'd8, 0);
    chk_reg("R12 resp0", 4'd2, 0);
    chk("R12 irq", {31'b0, irq}, 0);
    chk("R12 start", {31'b0, ser_start}, 0);

    // R1/R3 data read command
    issue(mk(17, 1, 1, 1, 2), 32'h1234_5678, 1);
    chk_reg("R1 R3 status after accept", 4'd6, 3);
    // R2 blocked by command inhibit
    issue(mk(13, 0, 0, 0, 2), 32'h0000_0013, 0);
    chk_reg("R2 status unchanged", 4'd6, 3);
    respond(128'hAABB_CCDD, 6'd17, 0, 0, 0);
    chk_reg("R4 status", 4'd6, 2);
    chk_reg("R4 istat cmd done", 4'd8, 1);
    chk_reg("R5 resp48", 4'd2, 32'hAABB_CCDD);

    // R2 data inhibit: data command refused, plain command accepted
    issue(mk(24, 1, 0, 0, 2), 32'h0000_0024, 0);
    chk_reg("R2 data cmd refused", 4'd6, 2);
    issue(mk(13, 0, 0, 0, 2), 32'h0000_0D0D, 1);
    chk_reg("R2 plain cmd accepted", 4'd6, 3);
    respond(128'h1, 6'd13, 0, 0, 0);

    // R8 data path events
    @(negedge clk); data_done = 1; data_err = 3'b010;
    @(negedge clk); data_done = 0; data_err = 0;
    chk_reg("R8 status free", 4'd6, 0);
    chk_reg("R8 istat xfer+dcrc", 4'd8, 32'h0020_0003);
    @(negedge clk); acmd_err = 1; wr_rdy = 1; rd_rdy = 1;
    @(negedge clk); acmd_err = 0; wr_rdy = 0; rd_rdy = 0;
    chk_reg("R8 istat misc", 4'd8, 32'h0120_0033);

    // R9 W1C
    wr(4'd8, 32'h0000_0021);
    chk_reg("R9 clear ones", 4'd8, 32'h0120_0012);
    wr(4'd8, 32'h0);
    chk_reg("R9 zero keeps", 4'd8, 32'h0120_0012);

    // R10 irq
    chk("R10 irq masked", {31'b0, irq}, 0);
    wr(4'd9, 32'h10);
    chk("R10 irq enabled", {31'b0, irq}, 1);
    wr(4'd8, 32'hFFFF_FFFF);
    chk_reg("R9 clear all", 4'd8, 0);
    chk("R10 irq low", {31'b0, irq}, 0);

    // R9 event and clear in the same cycle
    @(negedge clk); wr_rdy = 1;
    @(negedge clk); wr_rdy = 1; wr_en = 1; wr_addr = 4'd8; wr_data = 32'h10;
    @(negedge clk); wr_rdy = 0; wr_en = 0;
    chk_reg("R9 set wins", 4'd8, 32'h10);
    wr(4'd8, 32'h10);
    wr(4'd9, 32'h0);

    // R5 136-bit packing
    issue(mk(2, 0, 0, 0, 1), 32'h0, 1);
    respond(128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 6'd63, 0, 0, 0);
    chk_reg("R5 w0", 4'd2, 32'hBBCC_DDEE);
    chk_reg("R5 w1", 4'd3, 32'h7788_99AA);
    chk_reg("R5 w2", 4'd4, 32'h3344_5566);
    chk_reg("R5 w3", 4'd5, 32'h0000_1122);
    chk_reg("R6 no index check on long", 4'd8, 1);
    wr(4'd8, 32'hFFFF_FFFF);

    // R6 index error, CRC ignored when disabled
    issue(mk(3, 0, 1, 0, 2), 32'h3, 1);
    respond(128'h5, 6'd5, 0, 1, 0);
    chk_reg("R6 index only", 4'd8, 32'h0008_0000);
    chk_reg("R6 status free", 4'd6, 0);
    wr(4'd8, 32'hFFFF_FFFF);
    // R6 CRC and end bit with CRC check enabled
    issue(mk(8, 0, 0, 1, 2), 32'h8, 1);
    respond(128'h600D_0012, 6'd8, 0, 1, 1);
    chk_reg("R6 crc+end", 4'd8, 32'h0006_0000);
    wr(4'd8, 32'hFFFF_FFFF);
    // R6 timeout masks others and stores nothing
    issue(mk(5, 0, 1, 1, 2), 32'h5, 1);
    respond(128'hDEAD, 6'd1, 1, 1, 1);
    chk_reg("R6 timeout", 4'd8, 32'h0001_0000);
    chk_reg("R6 resp kept", 4'd2, 32'h600D_0012);
    wr(4'd8, 32'hFFFF_FFFF);

    // R7 busy response
    issue(mk(7, 0, 1, 1, 3), 32'h7, 1);
    chk_reg("R3 busy sets data inhibit", 4'd6, 3);
    dat_busy = 1;
    respond(128'h7, 6'd7, 0, 0, 0);
    chk_reg("R7 after resp", 4'd6, 2);
    chk_reg("R7 istat before release", 4'd8, 1);
    repeat (3) @(negedge clk);
    chk_reg("R7 still busy", 4'd6, 2);
    dat_busy = 0;
    @(negedge clk);
    chk_reg("R7 released", 4'd6, 0);
    chk_reg("R7 xfer done", 4'd8, 3);
    wr(4'd8, 32'hFFFF_FFFF);

    // R11 command reset, late response ignored
    issue(mk(16, 0, 0, 0, 2), 32'h16, 1);
    chk_reg("R11 pending", 4'd6, 1);
    wr(4'd7, 32'h0200_0000);
    chk_reg("R11 reset bit visible", 4'd7, 32'h0200_0000);
    @(negedge clk);
    chk_reg("R11 cmd line free", 4'd6, 0);
    chk_reg("R11 reset bit self-clears", 4'd7, 0);
    respond(128'h16, 6'd16, 0, 0, 0);
    chk_reg("R11 late resp ignored", 4'd8, 0);

    // R11 data reset
    issue(mk(17, 1, 0, 0, 2), 32'h17, 1);
    respond(128'h17, 6'd17, 0, 0, 0);
    chk_reg("R11 data pending", 4'd6, 2);
    wr(4'd7, 32'h0400_0000);
    @(negedge clk);
    chk_reg("R11 data line free", 4'd6, 0);

    repeat (2) @(negedge clk);
    chk("R1 all launches seen", exp_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule